// File: doc/BRIEF.md
# System Counter with Target Comparator

This block is a free-running wide counter paired with a single comparator. Every access that crosses into the counter goes through a strobe and a fixed synchronisation delay, which stands in for a slower counting domain. A new counter value is placed on the load inputs and committed with a load strobe. A read is requested with a snapshot strobe. The requester then polls a valid flag and reads the captured value as a high word and a low word. The counter advances by one per clock while its run input is high and holds its value while the input is low.

The comparator takes a target and a period through its own strobe, with the same delay. When it is enabled and armed, it signals a match as soon as the counter is at or beyond the effective target. In one-shot mode a match disarms the comparator. In periodic mode each match moves the effective target forward by the period. A match sets a sticky status bit. A write-one clear input resets that bit, and a mask input decides whether the status drives the level interrupt output.

Top module: `sys_counter`

## Requirements
- R1: After reset the counter is 0, `snap_valid` is 0, `irq_status` is 0 and `irq` is 0.
- R2: While `run_en` is 1 the counter increases by one each clock, wrapping modulo 2^52. While `run_en` is 0 it holds its value.
- R3: `{load_hi, load_lo}` is captured on the clock edge where `load_stb` is 1, and the counter takes that value exactly SYNC_LAT edges later. Load inputs that change without a strobe, or after one, have no effect.
- R4: A `snap_req` clears `snap_valid` at the next edge. SYNC_LAT edges after the request edge, `snap_valid` becomes 1 and the snapshot holds the counter value. Both then stay unchanged until the next request.
- R5: The snapshot is split into `snap_hi`, which carries counter bits 51..32, and `snap_lo`, which carries bits 31..0.
- R6: `{tgt_hi, tgt_lo}` and `period_val` are captured on a `tgt_stb` edge and become effective SYNC_LAT edges later. At that point the comparator is re-armed.
- R7: While `cmp_en` is 0 no match is detected and `irq_status` is not set.
- R8: In one-shot mode (`cmp_periodic`=0) an armed, enabled comparator matches when the counter is at or above the target. It then disarms, so it fires only once per target load.
- R9: In periodic mode (`cmp_periodic`=1) each match adds the period to the effective target, so matches recur every period counts.
- R10: `irq_status` becomes 1 on the edge after a match. It returns to 0 on the edge where `irq_clr` is 1 and no match is present.
- R11: `irq` is a level output equal to 1 exactly when `irq_status` is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Counter advances while high |
| load_lo | input | 32 | Low word of new counter value |
| load_hi | input | 20 | High word of new counter value |
| load_stb | input | 1 | Commit the load value |
| snap_req | input | 1 | Request a counter snapshot |
| snap_valid | output | 1 | Snapshot is stable |
| snap_lo | output | 32 | Snapshot low word |
| snap_hi | output | 20 | Snapshot high word |
| tgt_lo | input | 32 | Low word of comparator target |
| tgt_hi | input | 20 | High word of comparator target |
| period_val | input | 52 | Increment applied per periodic match |
| tgt_stb | input | 1 | Commit target and period |
| cmp_en | input | 1 | Comparator enable |
| cmp_periodic | input | 1 | 1 selects periodic mode, 0 selects one-shot |
| irq_en | input | 1 | Interrupt mask |
| irq_clr | input | 1 | Write-one clear of status |
| irq_status | output | 1 | Sticky match status |
| irq | output | 1 | Level interrupt |

## Verification
The bench aims at the exact delay of each strobe. A load, target or snapshot that took effect one cycle early or late would show up as the wrong value or a misplaced flag on the checked cycle. A carry that failed to cross from bit 31 into the high word, or a wrap that was not modulo 2^52, would corrupt the snapshots taken across those boundaries. Two further checks separate an equality compare from an at-or-beyond compare: a comparator enabled with the counter already past the target, and a one-shot that fires again after clearing. Both would expose the wrong compare. Load data that changes after its strobe must not leak into the counter, and a periodic comparator that failed to advance its target would fire every cycle instead of once per period.

// File: rtl/sys_counter_pkg.sv
package sys_counter_pkg;
   typedef enum logic {
      CMP_ONESHOT  = 1'b0,
      CMP_PERIODIC = 1'b1
   } cmp_mode_e;
endpackage

// File: rtl/sys_counter_delay.sv
// Restartable fixed-latency tracker: fire pulses LAT edges after start.
module sys_counter_delay #(
   parameter int LAT = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic fire
);
   localparam int CW = $clog2(LAT + 1);

   if (LAT < 1) begin : g_bad_lat
      $error("sys_counter_delay: LAT must be at least 1");
   end

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               left_q <= '0;
      else if (start)           left_q <= CW'(LAT);
      else if (left_q != '0)    left_q <= left_q - 1'b1;
   end

   assign fire = (left_q == CW'(1));
endmodule

// File: rtl/sys_counter_core.sv
// Counter, staged load and snapshot capture.
module sys_counter_core #(
   parameter int CNT_W    = 52,
   parameter int SYNC_LAT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [CNT_W-1:0] load_val,
   input  logic             load_stb,
   input  logic             snap_req,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ld_fire,
   output logic [CNT_W-1:0] snap_q,
   output logic             snap_valid_q
);
   logic [CNT_W-1:0] stage_q;
   logic             snap_fire;

   sys_counter_delay #(.LAT(SYNC_LAT)) u_ld_dly (
      .clk(clk), .rst_n(rst_n), .start(load_stb), .fire(ld_fire)
   );

   sys_counter_delay #(.LAT(SYNC_LAT)) u_snap_dly (
      .clk(clk), .rst_n(rst_n), .start(snap_req), .fire(snap_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stage_q <= '0;
      else if (load_stb) stage_q <= load_val;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (ld_fire) cnt_q <= stage_q;
      else if (run_en)  cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snap_q       <= '0;
         snap_valid_q <= 1'b0;
      end else if (snap_req) begin
         snap_valid_q <= 1'b0;
      end else if (snap_fire) begin
         snap_q       <= cnt_q;
         snap_valid_q <= 1'b1;
      end
   end
endmodule

// File: rtl/sys_counter_cmp.sv
// Comparator with staged target, one-shot / periodic arming and status.
module sys_counter_cmp
   import sys_counter_pkg::*;
#(
   parameter int CNT_W       = 52,
   parameter int SYNC_LAT    = 3,
   parameter bit PERIODIC_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] tgt_val,
   input  logic [CNT_W-1:0] period_val,
   input  logic             tgt_stb,
   input  logic             cmp_en,
   input  logic             cmp_periodic,
   input  logic             irq_en,
   input  logic             irq_clr,
   output logic             match,
   output logic             irq_status_q,
   output logic             irq
);
   logic [CNT_W-1:0] pend_tgt_q, pend_per_q, eff_tgt_q, eff_per_q;
   logic             armed_q;
   logic             tgt_fire;
   cmp_mode_e        mode;

   sys_counter_delay #(.LAT(SYNC_LAT)) u_tgt_dly (
      .clk(clk), .rst_n(rst_n), .start(tgt_stb), .fire(tgt_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_tgt_q <= '0;
         pend_per_q <= '0;
      end else if (tgt_stb) begin
         pend_tgt_q <= tgt_val;
         pend_per_q <= period_val;
      end
   end

   assign match = cmp_en && armed_q && (cnt >= eff_tgt_q);

   if (PERIODIC_EN) begin : g_periodic
      assign mode = cmp_mode_e'(cmp_periodic);
   end else begin : g_oneshot_only
      logic unused_mode;
      assign unused_mode = cmp_periodic;
      assign mode        = CMP_ONESHOT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eff_tgt_q <= '0;
         eff_per_q <= '0;
         armed_q   <= 1'b0;
      end else if (tgt_fire) begin
         eff_tgt_q <= pend_tgt_q;
         eff_per_q <= pend_per_q;
         armed_q   <= 1'b1;
      end else if (match) begin
         if (mode == CMP_PERIODIC) eff_tgt_q <= eff_tgt_q + eff_per_q;
         else                      armed_q   <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       irq_status_q <= 1'b0;
      else if (match)   irq_status_q <= 1'b1;
      else if (irq_clr) irq_status_q <= 1'b0;
   end

   assign irq = irq_status_q & irq_en;
endmodule

// File: rtl/sys_counter.sv
module sys_counter #(
   parameter int LO_W        = 32,
   parameter int HI_W        = 20,
   parameter int SYNC_LAT    = 3,
   parameter bit PERIODIC_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_en,
   input  logic [LO_W-1:0] load_lo,
   input  logic [HI_W-1:0] load_hi,
   input  logic            load_stb,
   input  logic            snap_req,
   output logic            snap_valid,
   output logic [LO_W-1:0] snap_lo,
   output logic [HI_W-1:0] snap_hi,
   input  logic [LO_W-1:0] tgt_lo,
   input  logic [HI_W-1:0] tgt_hi,
   input  logic [LO_W+HI_W-1:0] period_val,
   input  logic            tgt_stb,
   input  logic            cmp_en,
   input  logic            cmp_periodic,
   input  logic            irq_en,
   input  logic            irq_clr,
   output logic            irq_status,
   output logic            irq
);
   localparam int CNT_W = LO_W + HI_W;

   if (LO_W < 1 || HI_W < 1) begin : g_bad_w
      $error("sys_counter: word widths must be positive");
   end

   logic [CNT_W-1:0] cnt_q, snap_q;
   logic             ld_fire, match;

   sys_counter_core #(.CNT_W(CNT_W), .SYNC_LAT(SYNC_LAT)) u_core (
      .clk(clk), .rst_n(rst_n), .run_en(run_en),
      .load_val({load_hi, load_lo}), .load_stb(load_stb),
      .snap_req(snap_req), .cnt_q(cnt_q), .ld_fire(ld_fire),
      .snap_q(snap_q), .snap_valid_q(snap_valid)
   );

   sys_counter_cmp #(.CNT_W(CNT_W), .SYNC_LAT(SYNC_LAT),
                     .PERIODIC_EN(PERIODIC_EN)) u_cmp (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q),
      .tgt_val({tgt_hi, tgt_lo}), .period_val(period_val),
      .tgt_stb(tgt_stb), .cmp_en(cmp_en), .cmp_periodic(cmp_periodic),
      .irq_en(irq_en), .irq_clr(irq_clr), .match(match),
      .irq_status_q(irq_status), .irq(irq)
   );

   assign snap_lo = snap_q[LO_W-1:0];
   assign snap_hi = snap_q[CNT_W-1:LO_W];
endmodule

// File: rtl/sys_counter_chk.sv
module sys_counter_chk #(
   parameter int CNT_W = 52
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic [CNT_W-1:0] cnt_q,
   input logic             ld_fire,
   input logic             snap_req,
   input logic             snap_valid,
   input logic [CNT_W-1:0] snap_q,
   input logic             cmp_en,
   input logic             irq_clr,
   input logic             irq_en,
   input logic             irq_status,
   input logic             irq
);
   p_cnt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !ld_fire) |=> (cnt_q == $past(cnt_q)));

   p_cnt_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (run_en && !ld_fire) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

   p_valid_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      snap_req |=> !snap_valid);

   p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (snap_valid && !snap_req) |=> (snap_valid && $stable(snap_q)));

   p_no_match_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cmp_en && !irq_status) |=> !irq_status);

   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !cmp_en) |=> !irq_status);

   p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_en || !irq_status) |-> !irq);
endmodule

bind sys_counter sys_counter_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .run_en(run_en), .cnt_q(cnt_q),
   .ld_fire(ld_fire), .snap_req(snap_req), .snap_valid(snap_valid),
   .snap_q(snap_q), .cmp_en(cmp_en), .irq_clr(irq_clr),
   .irq_en(irq_en), .irq_status(irq_status), .irq(irq)
);

// File: tb/sys_counter_tb.sv
`timescale 1ns/1ps
module sys_counter_tb;
   localparam int LAT = 3;
   localparam logic [51:0] MASK = {52{1'b1}};
   localparam int NV = 5;
   localparam logic [51:0] TV_LD [NV] = '{52'h0, 52'd5, 52'hF_FFFF_FFFF_FFFD,
                                          52'h0_0000_FFFF_FFFF, 52'h0_0123_4567_89AB};
   localparam int TV_N [NV] = '{0, 10, 5, 1, 7};

   logic        clk = 0, rst_n = 0;
   logic        run_en = 0, load_stb = 0, snap_req = 0, tgt_stb = 0;
   logic [31:0] load_lo = 0, tgt_lo = 0, snap_lo;
   logic [19:0] load_hi = 0, tgt_hi = 0, snap_hi;
   logic [51:0] period_val = 0;
   logic        cmp_en = 0, cmp_periodic = 0, irq_en = 0, irq_clr = 0;
   logic        snap_valid, irq_status, irq;
   int          n_tests = 0, n_fail = 0;
   logic        done = 0;

   always #2 clk = ~clk;

   sys_counter #(.SYNC_LAT(LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .load_lo(load_lo),
      .load_hi(load_hi), .load_stb(load_stb), .snap_req(snap_req),
      .snap_valid(snap_valid), .snap_lo(snap_lo), .snap_hi(snap_hi),
      .tgt_lo(tgt_lo), .tgt_hi(tgt_hi), .period_val(period_val),
      .tgt_stb(tgt_stb), .cmp_en(cmp_en), .cmp_periodic(cmp_periodic),
      .irq_en(irq_en), .irq_clr(irq_clr), .irq_status(irq_status), .irq(irq)
   );

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_load(input logic [51:0] v);
      load_lo = v[31:0]; load_hi = v[51:32]; load_stb = 1;
      step(1);
      load_stb = 0;
      step(LAT);
   endtask

   task automatic do_snap(output logic [63:0] v);
      snap_req = 1;
      step(1);
      snap_req = 0;
      for (int i = 0; i < 20 && !snap_valid; i++) step(1);
      v = {12'h0, snap_hi, snap_lo};
   endtask

   task automatic do_target(input logic [51:0] t, input logic [51:0] p);
      tgt_lo = t[31:0]; tgt_hi = t[51:32]; period_val = p; tgt_stb = 1;
      step(1);
      tgt_stb = 0;
      step(LAT);
   endtask

   task automatic pulse_clr();
      irq_clr = 1; step(1); irq_clr = 0;
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [63:0] v;
      int k1, k2;
      step(3);
      rst_n = 1;
      step(1);
      // R1 reset state
      check("R1 valid", {63'h0, snap_valid}, 64'h0);
      check("R1 status", {63'h0, irq_status}, 64'h0);
      check("R1 irq", {63'h0, irq}, 64'h0);
      do_snap(v);
      check("R1 counter", v, 64'h0);

      // R2 R3 R5: vector table, load then run n cycles then snapshot
      for (int i = 0; i < NV; i++) begin
         do_load(TV_LD[i]);
         run_en = 1; step(TV_N[i]); run_en = 0;
         do_snap(v);
         check("R2 R3 R5 table", v, {12'h0, (TV_LD[i] + 52'(TV_N[i])) & MASK});
      end

      // R4 valid timing while frozen at a known value
      do_load(52'h0_00AB_0000_0042);
      snap_req = 1; step(1); snap_req = 0;
      check("R4 valid cleared", {63'h0, snap_valid}, 64'h0);
      step(LAT - 1);
      check("R4 valid before latency", {63'h0, snap_valid}, 64'h0);
      step(1);
      check("R4 valid after latency", {63'h0, snap_valid}, 64'h1);
      check("R4 R5 value", {12'h0, snap_hi, snap_lo}, 64'h00AB_0000_0042);

      // R2 running snapshot: capture lands LAT edges after request
      do_load(52'h0_0000_0000_0100);
      run_en = 1; snap_req = 1; step(1); snap_req = 0;
      for (int i = 0; i < 20 && !snap_valid; i++) step(1);
      run_en = 0;
      check("R2 R4 running snapshot", {12'h0, snap_hi, snap_lo}, 64'h100 + LAT);

      // R3 ignored load data: no strobe, and change after strobe
      do_load(52'h77);
      load_lo = 32'hDEAD; load_hi = 20'h5; step(6);
      do_snap(v);
      check("R3 no strobe ignored", v, 64'h77);
      load_lo = 32'h11; load_hi = 0; load_stb = 1; step(1);
      load_stb = 0; load_lo = 32'h99; step(LAT + 2);
      do_snap(v);
      check("R3 post-strobe change ignored", v, 64'h11);

      // R7 disabled comparator, counter past target
      do_load(52'd100);
      cmp_en = 0; cmp_periodic = 0; irq_en = 1;
      do_target(52'd50, 52'd0);
      step(5);
      check("R7 disabled no status", {63'h0, irq_status}, 64'h0);
      cmp_en = 1; step(1);
      check("R8 at-or-beyond match", {63'h0, irq_status}, 64'h1);
      check("R11 irq when enabled", {63'h0, irq}, 64'h1);
      irq_en = 0; #1;
      check("R11 masked irq", {63'h0, irq}, 64'h0);
      check("R11 status kept", {63'h0, irq_status}, 64'h1);
      irq_en = 1;
      pulse_clr();
      check("R10 cleared", {63'h0, irq_status}, 64'h0);
      step(5);
      check("R8 one-shot no refire", {63'h0, irq_status}, 64'h0);

      // R6 target latency with counter frozen at 100
      tgt_lo = 32'd80; tgt_hi = 0; tgt_stb = 1; step(1); tgt_stb = 0;
      check("R6 no early effect", {63'h0, irq_status}, 64'h0);
      step(LAT);
      check("R6 not before latency", {63'h0, irq_status}, 64'h0);
      step(1);
      check("R6 effective after latency", {63'h0, irq_status}, 64'h1);
      pulse_clr();

      // R8 R10 one-shot match timing while running
      cmp_en = 0;
      do_load(52'd0);
      do_target(52'd20, 52'd0);
      cmp_en = 1; run_en = 1;
      step(20);
      check("R10 status not before match", {63'h0, irq_status}, 64'h0);
      step(1);
      check("R8 R10 status one edge after match", {63'h0, irq_status}, 64'h1);
      pulse_clr();
      step(10);
      check("R8 single fire while running", {63'h0, irq_status}, 64'h0);
      run_en = 0; cmp_en = 0;

      // R9 periodic: matches every 10 counts
      do_load(52'd0);
      cmp_periodic = 1;
      do_target(52'd10, 52'd10);
      cmp_en = 1; run_en = 1;
      k1 = 0; k2 = 0;
      for (int k = 1; k <= 40; k++) begin
         step(1);
         if (irq_status) begin
            if (k1 == 0) k1 = k; else if (k2 == 0) k2 = k;
            irq_clr = 1;
         end else irq_clr = 0;
      end
      irq_clr = 0; run_en = 0; cmp_en = 0;
      check("R9 first periodic match", 64'(k1), 64'd11);
      check("R9 period interval", 64'(k2 - k1), 64'd10);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule